// File: doc/BRIEF.md
# Compressed Two-Wire Scan to Four-Wire JTAG Converter

This block sits behind the pin logic of a two-wire debug port. Once the port is in compressed scan mode, the single bidirectional data line carries three time-multiplexed values for every JTAG bit: the inverted test-data-in, the test-mode-select and the test-data-out. The converter watches the already-synchronised two-wire clock and data line with the system clock. It sorts each sampled value into its slot and, on the third slot, presents a complete JTAG bit triple together with a one-cycle strobe that stands in for the virtual test clock.

The slot order is fixed: inverted TDI, then TMS, then TDO, then back to inverted TDI. When compressed mode becomes active, the first sampled two-wire clock is taken as the TMS slot, so the first issued triple reuses the previously held TDI. Driving the data line back toward the probe, and the escape and activation sequences that switch modes, are handled elsewhere. The mode flag arrives from that logic.

Top module: `cscan_to_jtag`

## Requirements
- R1: While rst_n is low at a rising clk edge, the rebuilt TDI, TMS and TDO outputs and the strobe all become 0.
- R2: A two-wire clock rise taken in the inverted-TDI slot (slot 0) stores the complement of tmsc_i as the next TDI, so tmsc_i = 0 yields TDI = 1.
- R3: A two-wire clock rise taken in the TMS slot (slot 1) stores tmsc_i unchanged as the next TMS.
- R4: A two-wire clock rise taken in the TDO slot (slot 2) issues the triple. If tckc_i is low at one clk edge and high at the next, the outputs carry the stored TDI, the stored TMS and that sampled tmsc_i as TDO in the cycle after that second edge, and jtag_clk_stb_o is 1 in that cycle.
- R5: After slot 2 the slot order wraps to slot 0, so in steady compressed mode a triple is issued on every third two-wire clock rise.
- R6: When compressed mode becomes active, the first two-wire clock rise is taken as slot 1 (TMS). The first issued triple then carries the TDI held from before (0 after reset).
- R7: While cmode_i is low, two-wire clock rises are ignored, no strobe is produced, the outputs keep their values and the slot position returns to slot 1.
- R8: The TDI, TMS and TDO outputs change only in a cycle where the strobe is 1, and otherwise hold their last values.
- R9: The strobe lasts exactly one clk cycle per issued triple, however long tckc_i stays high.
- R10: Changes of tmsc_i while tckc_i does not rise have no effect on the outputs or on the stored slot values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tckc_i | input | 1 | Synchronised two-wire scan clock level |
| tmsc_i | input | 1 | Synchronised two-wire data line level |
| cmode_i | input | 1 | High while compressed scan mode is active |
| jtag_tdi_o | output | 1 | Rebuilt test data in |
| jtag_tms_o | output | 1 | Rebuilt test mode select |
| jtag_tdo_o | output | 1 | Rebuilt test data out |
| jtag_clk_stb_o | output | 1 | One-cycle virtual test-clock strobe, marks a new triple |

## Verification
A wrong slot position shows at the ports within three two-wire clock rises. The strobe then appears after the wrong rise, or the TMS and TDO bits come out swapped or shifted relative to what the bench sent. A wrong entry slot is exposed by the first triple after compressed mode starts, and a missing inversion by the first TDI bit issued. The bench rebuilds every expected triple from the values it sends, slot by slot, so any misplaced capture is caught no later than the next strobe.

// File: rtl/cscan_pkg.sv
// Package: shared slot definitions for the compressed scan converter.
// Assumes three slots per JTAG bit in the fixed order inverted TDI, TMS, TDO.
package cscan_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t SLOT_NTDI  = slot_t'(0);
    localparam slot_t SLOT_TMS   = slot_t'(1);
    localparam slot_t SLOT_TDO   = slot_t'(2);
    localparam slot_t SLOT_LAST  = slot_t'(NUM_SLOTS - 1);
    localparam slot_t SLOT_ENTRY = SLOT_TMS;
endpackage

// File: rtl/cscan_edge_det.sv
// Module: detects a low-to-high change of the two-wire clock level.
// Assumes the input is already synchronised to clk. The previous level
// resets high so that a line already high at reset gives no false rise.
module cscan_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Remember the level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R9
endmodule

// File: rtl/cscan_slot_seq.sv
// Module: tracks which slot the next two-wire clock rise belongs to and
// issues one capture enable per slot. Assumes rise_i lasts one cycle.
// Outside compressed mode the position is parked on ENTRY_SLOT.
module cscan_slot_seq
    import cscan_pkg::*;
#(
    parameter slot_t ENTRY_SLOT = SLOT_ENTRY
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic                 mode_i,
    output logic [NUM_SLOTS-1:0] cap_o
);
    slot_t slot_q;
    logic  adv;

    assign adv = rise_i & mode_i;

    // Step the slot position on each accepted rise, wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_i) slot_q <= ENTRY_SLOT;
        else if (adv)          slot_q <= (slot_q == SLOT_LAST) ? SLOT_NTDI : slot_q + 1'b1;
    end

    // One capture enable per slot, decoded from the current position.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cap
        assign cap_o[g] = adv && (slot_q == slot_t'(g));
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_LAST); // R5
    AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_o)); // R5
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o[SLOT_LAST] && mode_i) |=> (slot_q == SLOT_NTDI || !mode_i)); // R5
    AST_PARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> slot_q == ENTRY_SLOT); // R7
    AST_NO_CAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> cap_o == '0); // R7
endmodule

// File: rtl/cscan_bit_asm.sv
// Module: collects the slot values and issues a JTAG bit triple with a
// one-cycle strobe on the TDO slot. Assumes at most one capture enable
// is high per cycle. The TDI slot arrives inverted on the line.
module cscan_bit_asm
    import cscan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] cap_i,
    input  logic                 data_i,
    output logic                 tdi_o,
    output logic                 tms_o,
    output logic                 tdo_o,
    output logic                 stb_o
);
    logic tdi_hold;
    logic tms_hold;

    // Store the inverted-TDI and TMS slots until the triple is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdi_hold <= 1'b0;
            tms_hold <= 1'b0;
        end else begin
            if (cap_i[SLOT_NTDI]) tdi_hold <= ~data_i;
            if (cap_i[SLOT_TMS])  tms_hold <= data_i;
        end
    end

    // Issue the triple and the strobe on the TDO slot, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdi_o <= 1'b0;
            tms_o <= 1'b0;
            tdo_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= cap_i[SLOT_TDO];
            if (cap_i[SLOT_TDO]) begin
                tdi_o <= tdi_hold;
                tms_o <= tms_hold;
                tdo_o <= data_i;
            end
        end
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o); // R9
    AST_ISSUE_STB: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i[SLOT_TDO] |=> stb_o); // R4
    AST_TDO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i[SLOT_TDO] |=> tdo_o == $past(data_i)); // R4
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_o |-> $stable({tdi_o, tms_o, tdo_o})); // R8
endmodule

// File: rtl/cscan_to_jtag.sv
// Module: top of the compressed two-wire to four-wire JTAG converter.
// Assumes tckc_i and tmsc_i are synchronised to clk and that each
// two-wire clock level lasts at least one clk cycle.
module cscan_to_jtag
    import cscan_pkg::*;
#(
    parameter slot_t ENTRY_SLOT = SLOT_ENTRY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tckc_i,
    input  logic tmsc_i,
    input  logic cmode_i,
    output logic jtag_tdi_o,
    output logic jtag_tms_o,
    output logic jtag_tdo_o,
    output logic jtag_clk_stb_o
);
    logic                 tckc_rise;
    logic [NUM_SLOTS-1:0] cap;

    cscan_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (tckc_i),
        .rise_o  (tckc_rise)
    );

    cscan_slot_seq #(.ENTRY_SLOT(ENTRY_SLOT)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (tckc_rise),
        .mode_i (cmode_i),
        .cap_o  (cap)
    );

    cscan_bit_asm u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .data_i (tmsc_i),
        .tdi_o  (jtag_tdi_o),
        .tms_o  (jtag_tms_o),
        .tdo_o  (jtag_tdo_o),
        .stb_o  (jtag_clk_stb_o)
    );

    AST_STB_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_clk_stb_o |-> $past(cmode_i)); // R7
    AST_STB_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_clk_stb_o |-> ($past(tckc_i) && !$past(tckc_i, 2))); // R4
endmodule

// File: tb/cscan_to_jtag_tb.sv
module cscan_to_jtag_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tckc = 1'b0;
    logic tmsc = 1'b0;
    logic cmode = 1'b0;
    logic tdi, tms, tdo, stb;

    int n_checks = 0;
    int n_fail = 0;

    // Bench model of the converter
    int   m_slot = 1;
    logic m_tdi_hold = 1'b0;
    logic m_tms_hold = 1'b0;
    logic e_tdi = 1'b0, e_tms = 1'b0, e_tdo = 1'b0;

    always #10 clk = ~clk;

    cscan_to_jtag u_dut (
        .clk(clk), .rst_n(rst_n), .tckc_i(tckc), .tmsc_i(tmsc), .cmode_i(cmode),
        .jtag_tdi_o(tdi), .jtag_tms_o(tms), .jtag_tdo_o(tdo), .jtag_clk_stb_o(stb)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {tdi,tms,tdo,stb} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Model one two-wire clock rise; returns 1 if a triple is expected.
    function automatic logic model_edge(input logic v, input logic mode);
        logic issue = 1'b0;
        if (!mode) begin
            m_slot = 1;
            return 1'b0;
        end
        case (m_slot)
            0: m_tdi_hold = ~v;
            1: m_tms_hold = v;
            default: begin
                e_tdi = m_tdi_hold; e_tms = m_tms_hold; e_tdo = v; issue = 1'b1;
            end
        endcase
        m_slot = (m_slot == 2) ? 0 : m_slot + 1;
        return issue;
    endfunction

    // One two-wire clock: low phase, rise, check, then a high phase with
    // the data line toggling freely.
    task automatic send_edge(input logic v, input logic mode, input int hold_hi,
                             input string req);
        logic issue;
        @(negedge clk);
        tckc = 1'b0; tmsc = v; cmode = mode;
        @(negedge clk);
        tckc = 1'b1;
        issue = model_edge(v, mode);
        @(negedge clk);
        check(req, {tdi, tms, tdo, stb}, {e_tdi, e_tms, e_tdo, issue});
        for (int i = 0; i < hold_hi; i++) begin
            tmsc = 1'($urandom);
            @(negedge clk);
            check("R9/R10", {tdi, tms, tdo, stb}, {e_tdi, e_tms, e_tdo, 1'b0});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", {tdi, tms, tdo, stb}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {tdi, tms, tdo, stb}, 4'b0000);

        // R7: rises while mode is off do nothing
        send_edge(1'b1, 1'b0, 0, "R7");
        send_edge(1'b1, 1'b0, 0, "R7");
        send_edge(1'b0, 1'b0, 0, "R7");

        // R6: entry starts on TMS slot; held TDI is 0
        send_edge(1'b1, 1'b1, 0, "R6");   // TMS = 1
        send_edge(1'b0, 1'b1, 0, "R6");   // TDO = 0, triple {0,1,0}

        // R2, R3, R4: line 0 gives TDI 1
        send_edge(1'b0, 1'b1, 0, "R2");
        send_edge(1'b1, 1'b1, 0, "R3");
        send_edge(1'b1, 1'b1, 0, "R4");   // triple {1,1,1}
        // line 1 gives TDI 0
        send_edge(1'b1, 1'b1, 0, "R2");
        send_edge(1'b0, 1'b1, 0, "R3");
        send_edge(1'b1, 1'b1, 4, "R4");   // long high: R9, R10

        // R5: wrap, several frames
        for (int k = 0; k < 6; k++) send_edge(1'(k), 1'b1, 0, "R5");

        // R7 mid-frame exit then R6 re-entry
        send_edge(1'b0, 1'b1, 0, "R5");
        send_edge(1'b1, 1'b0, 0, "R7");
        send_edge(1'b1, 1'b1, 0, "R6");
        send_edge(1'b0, 1'b1, 0, "R6");

        // R8: no rise at all, data toggles, outputs hold
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tmsc = ~tmsc;
            check("R8", {tdi, tms, tdo, stb}, {e_tdi, e_tms, e_tdo, 1'b0});
        end

        // Random phase
        for (int k = 0; k < 400; k++) begin
            send_edge(1'($urandom), ($urandom % 10) != 0, $urandom % 3, "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule